// File: doc/BRIEF.md
# Dual-Channel Word Fill Engine

This block sits inside a memory-mapped graphics register space and clears or paints regions of memory with a constant 32-bit pattern. Each of its fill channels owns a group of four word registers. Software first writes the lower and upper bounds of the region. A write to the last word of the group then carries the pattern and, as a side effect, launches the fill. A zero lower bound suppresses the launch.

While a channel runs, it walks upward from the lower bound through a word-wide write port and issues one word per accepted handshake. It stops before the upper bound. The pattern reaches memory with its byte order reversed. Both channels share the one write port, and the lower-numbered channel has precedence. Each channel reports a busy level and a one-cycle completion pulse.

Top module: `fill_engine`

## Requirements
- R1: A register write at word index `i` addresses channel `i>>2` at offset `i[1:0]`. Offset 0 holds the lower bound and offset 1 the upper bound. Offset 2 is a size word that is accepted and discarded. Offset 3 carries the pattern and is the launch. Writes to offsets 0 to 2 never cause a memory write.
- R2: A launch that finds its channel idle with a nonzero lower bound and an upper bound above it raises `busy` and `mem_wr_valid` in the next cycle.
- R3: A launch that finds a zero stored lower bound produces no memory write, no busy and no done.
- R4: The fill writes byte addresses lower, lower+4, and so on up to upper-4, one for each cycle in which `mem_wr_valid` and `mem_wr_ready` are both high. The upper bound is never written. Address bits [1:0] of both bounds are treated as zero.
- R5: Every written word equals the launch pattern with its byte order reversed: bits [7:0] go to [31:24], bits [15:8] to [23:16], and so on.
- R6: The value written to the size word has no effect on how many words are written.
- R7: `busy` stays high from the cycle after the launch until the cycle after the last accepted write. While `mem_wr_ready` is low, the offered address and data hold.
- R8: `done` pulses for exactly one cycle, in the cycle after the last accepted write. A launch with an upper bound at or below the lower bound writes nothing, never raises busy, and pulses `done` in the next cycle.
- R9: A launch at a busy channel is ignored. Rewriting a busy channel's bounds does not alter the fill in progress.
- R10: When both channels are busy, channel 0 owns the write port until it finishes, and channel 1 waits with its position held.
- R11: After reset, `busy`, `done` and `mem_wr_valid` are low and the stored bounds are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | IDX_W (3) | Word index of the register written |
| reg_wr_data | input | 32 | Register write data |
| mem_wr_valid | output | 1 | Memory write offered |
| mem_wr_addr | output | ADDR_W | Byte address of the offered word |
| mem_wr_data | output | 32 | Word to be stored |
| mem_wr_ready | input | 1 | Memory accepts the offered word |
| busy | output | NUM_CH | Per-channel fill in progress |
| done | output | NUM_CH | Per-channel one-cycle completion pulse |

## Verification
The bench builds the engine with two channels and a 16-bit address. This keeps the top of the address range within reach, so a fill ending at the last aligned word is exercised without the wrapped cursor overrunning. The port is driven with ready held high, toggling every cycle, and randomly stalled. Both channels are launched with overlapping lifetimes, which brings the precedence and hold behaviour of the second channel into view.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef enum logic [1:0] {
    OFF_LO    = 2'd0,
    OFF_HI    = 2'd1,
    OFF_SIZE  = 2'd2,
    OFF_PAT   = 2'd3
  } cfg_off_e;

  function automatic logic [31:0] swap_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/fill_cfg_regs.sv
module fill_cfg_regs
  import fill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_CH = 2,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [CH_W-1:0]                wr_ch,
  input  logic [1:0]                     wr_off,
  input  logic [ADDR_W-3:0]              wr_word,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  lo_q,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  hi_q,
  output logic [NUM_CH-1:0]              launch
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel       = wr_en && (wr_ch == CH_W'(c));
    assign launch[c] = sel && (cfg_off_e'(wr_off) == OFF_PAT);

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[c] <= '0;
        hi_q[c] <= '0;
      end else if (sel) begin
        if (cfg_off_e'(wr_off) == OFF_LO) lo_q[c] <= {wr_word, 2'b00};
        if (cfg_off_e'(wr_off) == OFF_HI) hi_q[c] <= {wr_word, 2'b00};
      end
    end

    a_r11_lo_aligned: assert property (@(posedge clk) disable iff (rst)
      lo_q[c][1:0] == 2'b00);
  end
endmodule

// File: rtl/fill_channel.sv
module fill_channel
  import fill_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [31:0]       pattern,
  input  logic [ADDR_W-1:0] cfg_lo,
  input  logic [ADDR_W-1:0] cfg_hi,
  input  logic              grant,
  input  logic              ready,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [31:0]       fill_word
);
  logic              busy_q, done_q;
  logic [ADDR_W-1:0] cur_q, stop_q;
  logic [31:0]       word_q;
  logic              advance;

  assign advance = busy_q && grant && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cur_q  <= '0;
      stop_q <= '0;
      word_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (advance) begin
        cur_q <= cur_q + STEP;
        if (cur_q + STEP >= stop_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (!busy_q && launch && (cfg_lo != '0)) begin
        if (cfg_hi > cfg_lo) begin
          busy_q <= 1'b1;
          cur_q  <= cfg_lo;
          stop_q <= cfg_hi;
          word_q <= swap_bytes(pattern);
        end else begin
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign cur_addr  = cur_q;
  assign fill_word = word_q;

  a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cur_q < stop_q) && (cur_q[1:0] == 2'b00));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !(grant && ready)) |=> busy_q && $stable(cur_q) && $stable(word_q));
  a_r8_done_on_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  a_r9_word_stable: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !busy_q || $stable(word_q));
endmodule

// File: rtl/fill_port_sel.sv
module fill_port_sel #(
  parameter int ADDR_W = 32,
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0]              req,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]  addr_in,
  input  logic [NUM_CH-1:0][31:0]        data_in,
  output logic [NUM_CH-1:0]              grant,
  output logic                           valid,
  output logic [ADDR_W-1:0]              addr,
  output logic [31:0]                    data
);
  always_comb begin
    grant = '0;
    addr  = '0;
    data  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        addr = addr_in[i];
        data = data_in[i];
      end
    end
  end
  assign valid = |req;
endmodule

// File: rtl/fill_engine.sv
module fill_engine
  import fill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_CH = 2,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int IDX_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [IDX_W-1:0]  reg_wr_idx,
  input  logic [31:0]       reg_wr_data,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  input  logic              mem_wr_ready,
  output logic [NUM_CH-1:0] busy,
  output logic [NUM_CH-1:0] done
);
  logic [NUM_CH-1:0][ADDR_W-1:0] lo_q, hi_q, cur;
  logic [NUM_CH-1:0][31:0]       words;
  logic [NUM_CH-1:0]             launch, grant;

  fill_cfg_regs #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_ch   (reg_wr_idx[IDX_W-1:2]),
    .wr_off  (reg_wr_idx[1:0]),
    .wr_word (reg_wr_data[ADDR_W-1:2]),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .launch  (launch)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    fill_channel #(.ADDR_W(ADDR_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .launch    (launch[c]),
      .pattern   (reg_wr_data),
      .cfg_lo    (lo_q[c]),
      .cfg_hi    (hi_q[c]),
      .grant     (grant[c]),
      .ready     (mem_wr_ready),
      .busy      (busy[c]),
      .done      (done[c]),
      .cur_addr  (cur[c]),
      .fill_word (words[c])
    );
  end

  fill_port_sel #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_sel (
    .req     (busy),
    .addr_in (cur),
    .data_in (words),
    .grant   (grant),
    .valid   (mem_wr_valid),
    .addr    (mem_wr_addr),
    .data    (mem_wr_data)
  );

  for (genvar c = 1; c < NUM_CH; c++) begin : g_prio_chk
    a_r10_lower_first: assert property (@(posedge clk) disable iff (rst)
      (busy[c] && |busy[c-1:0]) |=> $stable(cur[c]));
  end
  a_r2_valid_busy: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid == (busy != '0));
  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !mem_wr_valid && (done == '0));
endmodule

// File: tb/fill_engine_bench.sv
`timescale 1ns/1ps
module fill_engine_bench;
  localparam int AW = 16;
  localparam int HALF = 2.5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_wr_idx = '0;
  logic [31:0] reg_wr_data = '0;
  logic mem_wr_ready = 1'b1;
  logic mem_wr_valid;
  logic [AW-1:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic [1:0] busy, done;

  int checks = 0, errors = 0;
  int ready_mode = 0;
  int hs_count = 0;
  int done_cnt [2];
  logic [31:0] bmem [int];
  bit finished = 0;

  // behavioural reference state
  int m_lo_cfg [2], m_hi_cfg [2];
  int m_cur [2], m_stop [2];
  logic [31:0] m_word [2];
  bit m_busy [2], m_done [2];

  always #2.5 clk = ~clk;

  fill_engine #(.ADDR_W(AW), .NUM_CH(2)) u_fill_engine (
    .clk (clk), .rst (rst), .reg_wr_en (reg_wr_en), .reg_wr_idx (reg_wr_idx),
    .reg_wr_data (reg_wr_data), .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr (mem_wr_addr), .mem_wr_data (mem_wr_data),
    .mem_wr_ready (mem_wr_ready), .busy (busy), .done (done)
  );

  function automatic logic [31:0] rev(input logic [31:0] w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*(3-b) +: 8] = w[8*b +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model: advances on the same edges as the design
  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_lo_cfg[c] = 0; m_hi_cfg[c] = 0; m_cur[c] = 0; m_stop[c] = 0;
        m_word[c] = 0; m_busy[c] = 0; m_done[c] = 0;
      end
    end else begin
      bit was_busy [2];
      bit nd [2];
      int g;
      for (int c = 0; c < 2; c++) begin was_busy[c] = m_busy[c]; nd[c] = 0; end
      g = m_busy[0] ? 0 : (m_busy[1] ? 1 : -1);  // R10 channel 0 first
      if (g >= 0 && mem_wr_ready) begin
        m_cur[g] += 4;
        if (m_cur[g] >= m_stop[g]) begin m_busy[g] = 0; nd[g] = 1; end
      end
      if (reg_wr_en) begin
        int ch, off, a;
        ch = reg_wr_idx / 4; off = reg_wr_idx % 4;
        a = int'(reg_wr_data) & 32'h0000_FFFC;
        if (off == 0) m_lo_cfg[ch] = a;
        else if (off == 1) m_hi_cfg[ch] = a;
        else if (off == 3 && !was_busy[ch] && m_lo_cfg[ch] != 0) begin
          if (m_hi_cfg[ch] > m_lo_cfg[ch]) begin
            m_busy[ch] = 1; m_cur[ch] = m_lo_cfg[ch];
            m_stop[ch] = m_hi_cfg[ch]; m_word[ch] = rev(reg_wr_data);
          end else nd[ch] = 1;
        end
      end
      for (int c = 0; c < 2; c++) m_done[c] = nd[c];
    end
  end

  // ready pattern
  always @(negedge clk) begin
    #1;
    case (ready_mode)
      0: mem_wr_ready = 1'b1;
      1: mem_wr_ready = ~mem_wr_ready;
      default: mem_wr_ready = ($urandom % 3) != 0;
    endcase
  end

  // per-cycle comparison, sampled well clear of both edges
  always @(negedge clk) begin
    #2;
    if (!rst && !finished) begin
      bit ev;
      int eg;
      ev = m_busy[0] || m_busy[1];
      eg = m_busy[0] ? 0 : 1;
      check(mem_wr_valid == ev, "R2", "mem_wr_valid", mem_wr_valid, ev);
      if (ev && mem_wr_valid) begin
        check(int'(mem_wr_addr) == m_cur[eg], "R4", "mem_wr_addr", mem_wr_addr, m_cur[eg]);
        check(mem_wr_data == m_word[eg], "R5", "mem_wr_data", mem_wr_data, m_word[eg]);
      end
      for (int c = 0; c < 2; c++) begin
        check(busy[c] == m_busy[c], "R7", $sformatf("busy[%0d]", c), busy[c], m_busy[c]);
        check(done[c] == m_done[c], "R8", $sformatf("done[%0d]", c), done[c], m_done[c]);
        if (done[c]) done_cnt[c]++;
      end
      if (mem_wr_valid && mem_wr_ready) begin
        hs_count++;
        bmem[int'(mem_wr_addr)] = mem_wr_data;
      end
    end
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk); #1;
    reg_wr_en = 1'b1; reg_wr_idx = 3'(idx); reg_wr_data = d;
    @(negedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy[0] && !busy[1]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R7 watchdog busy actual=%0b expected=0", busy);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, d0;
    repeat (4) @(negedge clk);
    #1; rst = 1'b0;
    @(negedge clk); #2;
    // R11 reset state
    check(busy == 2'b00, "R11", "busy after reset", busy, 0);
    check(done == 2'b00, "R11", "done after reset", done, 0);
    check(!mem_wr_valid, "R11", "valid after reset", mem_wr_valid, 0);

    // R11 / R3: stored lower bound is zero after reset, launch does nothing
    base = hs_count; d0 = done_cnt[0];
    wr(3, 32'hDEAD_BEEF); settle();
    check(hs_count == base, "R3", "writes with zero lower bound", hs_count - base, 0);
    check(done_cnt[0] == d0, "R3", "done with zero lower bound", done_cnt[0] - d0, 0);

    // R1: offsets 0..2 never write memory
    base = hs_count;
    wr(0, 32'h100); wr(1, 32'h110); wr(2, 32'h0000_0001); settle();
    check(hs_count == base, "R1", "writes from config words", hs_count - base, 0);

    // R2 R4 R5 R6: basic fill, size word ignored
    base = hs_count;
    wr(3, 32'h1122_3344); settle();
    check(hs_count - base == 4, "R6", "word count", hs_count - base, 4);
    check(bmem.exists(32'h10C) && bmem[32'h10C] == 32'h4433_2211, "R5", "word at 0x10C",
          bmem.exists(32'h10C) ? bmem[32'h10C] : 0, 32'h4433_2211);
    check(!bmem.exists(32'h110), "R4", "upper bound untouched", bmem.exists(32'h110), 0);

    // R8: upper at or below lower
    base = hs_count; d0 = done_cnt[0];
    wr(0, 32'h200); wr(1, 32'h200); wr(3, 32'h5); settle();
    check(hs_count == base, "R8", "writes with empty range", hs_count - base, 0);
    check(done_cnt[0] == d0 + 1, "R8", "done pulses for empty range", done_cnt[0] - d0, 1);

    // R4: misaligned bounds, toggling ready
    ready_mode = 1;
    base = hs_count;
    wr(4, 32'h303); wr(5, 32'h313); wr(7, 32'hA1B2_C3D4); settle();
    check(hs_count - base == 4, "R4", "misaligned range count", hs_count - base, 4);
    check(bmem.exists(32'h300) && !bmem.exists(32'h310), "R4", "misaligned range ends",
          bmem.exists(32'h310), 0);

    // R9: relaunch and bound changes while busy are ignored
    ready_mode = 2;
    base = hs_count;
    wr(4, 32'h400); wr(5, 32'h440); wr(7, 32'h0102_0304);
    wr(7, 32'hFFFF_FFFF); wr(4, 32'h800); wr(5, 32'h900); settle();
    check(hs_count - base == 16, "R9", "count after busy relaunch", hs_count - base, 16);
    check(bmem[32'h43C] == 32'h0403_0201, "R9", "pattern kept", bmem[32'h43C], 32'h0403_0201);

    // R10: both channels running
    base = hs_count;
    wr(0, 32'h1000); wr(1, 32'h1040); wr(4, 32'h2000); wr(5, 32'h2020);
    wr(7, 32'h7777_0000); wr(3, 32'h0000_5555); settle();
    check(hs_count - base == 24, "R10", "combined count", hs_count - base, 24);
    check(bmem[32'h201C] == 32'h0000_7777, "R10", "channel 1 last word", bmem[32'h201C], 32'h0000_7777);

    // R4: top of the address range
    ready_mode = 0;
    base = hs_count;
    wr(0, 32'hFFF0); wr(1, 32'hFFFC); wr(3, 32'hCAFE_F00D); settle();
    check(hs_count - base == 3, "R4", "top of range count", hs_count - base, 3);
    check(!bmem.exists(32'hFFFC), "R4", "top word untouched", bmem.exists(32'hFFFC), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule